// File: doc/BRIEF.md
# Frame-Spanning Bit-Interleaved Parity Generator

This block computes an 8-bit bit-interleaved even parity over every octet of one transmit frame. The frame carries 12 rows of 54 octets, 648 octets in all, and both the path overhead bytes and the cell payload octets count. The result of one frame is the parity overhead byte carried by the following frame. Each of the eight output bits is an independent even parity over one bit position of all octets in the frame.

The frame assembler above this block presents octets on a byte-wide bus with a valid strobe. It marks the first octet of a frame with a start marker and the last octet with an end marker. The block folds each accepted octet into an accumulator. On the end-marked octet it latches the finished parity into a registered output. That output stays constant for the whole next frame, so the assembler can copy it into the overhead byte position whenever that position comes up. A length check flags frames that did not hold exactly 648 octets. A test input lets equipment send a deliberately wrong parity byte for one frame.

Top module: `frame_bip8_gen`

## Requirements
- R1: Bit n of `b1_out` (bit 7 the MSB) equals the XOR of bit n of every octet accepted in the frame, so an even number of ones in a bit position gives 0.
- R2: An octet is accepted only in a cycle with `in_valid` high. The `in_data` value in a cycle with `in_valid` low has no effect on the parity.
- R3: The parity of a frame appears on `b1_out` in the first cycle after its end-marked octet is accepted. It stays unchanged until the next end-marked octet is accepted, one frame later.
- R4: An accepted octet with `in_sof` high starts a new accumulation with that octet as its first member. Any partial accumulation before it is discarded.
- R5: At each accepted end-marked octet, `len_err` becomes 1 if the number of accepted octets from the start-marked octet through the end-marked octet, both included, differs from ROWS*COLS (648 by default). Otherwise it becomes 0. `b1_out` is updated in both cases.
- R6: If `err_inject` is high in the cycle the end-marked octet is accepted, `b1_out` shows the bitwise inverse of the computed parity for that one frame. `err_inject` in any other cycle has no effect.
- R7: While reset is active and after its release, `b1_out` is 8'h00 and `len_err` is 0 until the first end-marked octet is accepted.
- R8: `in_sof` and `in_eof` have no effect in a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Octet on `in_data` is accepted this cycle |
| in_data | input | 8 | Frame octet, bit 7 the MSB |
| in_sof | input | 1 | Accepted octet is the first of a frame |
| in_eof | input | 1 | Accepted octet is the last of a frame |
| err_inject | input | 1 | Invert the parity latched at this end-marked octet |
| b1_out | output | 8 | Parity byte of the previous complete frame |
| len_err | output | 1 | Previous frame had an accepted octet count other than 648 |

## Verification
The hardest situation to reach from the ports is a frame whose parity depends on exactly which cycles count. Such a frame has idle cycles carrying garbage data and stray start or end markers, a restart in the middle of a frame, or a length one off from 648. The stimulus puts random gaps between octets and fills each idle cycle with random data, markers and inject values. It also sends abandoned partial frames followed by fresh start markers, and frames of 647 and 649 octets. The expected parity and length flag come from a running model in the bench that counts only accepted octets.

// File: rtl/bip_pkg.sv
package bip_pkg;
    localparam int unsigned OCTET_W = 8;

    typedef logic [OCTET_W-1:0] octet_t;

    typedef struct packed {
        octet_t b1;
        logic   len_err;
    } hold_st_t;
endpackage

// File: rtl/bip_accum.sv
module bip_accum
    import bip_pkg::*;
#(
    parameter int unsigned ROWS = 12,
    parameter int unsigned COLS = 54
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  octet_t in_data,
    input  logic   in_sof,
    input  logic   in_eof,
    output logic   frame_done,
    output octet_t frame_par,
    output logic   frame_len_ok
);
    localparam int unsigned FRAME_LEN = ROWS * COLS;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOAL = CNT_W'(FRAME_LEN);

    typedef struct packed {
        octet_t           acc;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    octet_t           base_acc;
    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        base_acc = in_sof ? '0 : st_q.acc;
        base_cnt = in_sof ? '0 : st_q.cnt;
        next_cnt = (base_cnt == CNT_MAX) ? base_cnt : base_cnt + 1'b1;
        if (in_valid) begin
            if (in_eof) begin
                st_d = '0;
            end else begin
                st_d.acc = base_acc ^ in_data;
                st_d.cnt = next_cnt;
            end
        end
        frame_done   = in_valid & in_eof;
        frame_par    = base_acc ^ in_data;
        frame_len_ok = (next_cnt == CNT_GOAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: after the end-marked octet the accumulator is empty again
    p_eof_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> (st_q.acc == '0 && st_q.cnt == '0));

    // R4: a start-marked octet becomes the sole member of a new frame
    p_sof_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> (st_q.cnt == 1 && st_q.acc == $past(in_data)));

    // R2, R8: idle cycles leave the accumulation untouched
    p_idle_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));
endmodule

// File: rtl/bip_hold.sv
module bip_hold
    import bip_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_done,
    input  octet_t frame_par,
    input  logic   frame_len_ok,
    input  logic   err_inject,
    output octet_t b1,
    output logic   len_err
);
    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_done) begin
            st_d.b1      = err_inject ? ~frame_par : frame_par;
            st_d.len_err = ~frame_len_ok;
        end
        b1      = st_q.b1;
        len_err = st_q.len_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the byte holds for the whole frame between end markers
    p_b1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(st_q));

    // R6: injection inverts the latched parity
    p_inject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && err_inject) |=> (b1 == ~$past(frame_par)));

    // R5: a wrong octet count raises the length flag
    p_len_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_len_ok) |=> len_err);
endmodule

// File: rtl/frame_bip8_gen.sv
module frame_bip8_gen
    import bip_pkg::*;
#(
    parameter int unsigned ROWS = 12,
    parameter int unsigned COLS = 54
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       err_inject,
    output logic [7:0] b1_out,
    output logic       len_err
);
    logic   frame_done;
    octet_t frame_par;
    logic   frame_len_ok;

    bip_accum #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_sof       (in_sof),
        .in_eof       (in_eof),
        .frame_done   (frame_done),
        .frame_par    (frame_par),
        .frame_len_ok (frame_len_ok)
    );

    bip_hold u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (frame_done),
        .frame_par    (frame_par),
        .frame_len_ok (frame_len_ok),
        .err_inject   (err_inject),
        .b1           (b1_out),
        .len_err      (len_err)
    );

    // R7: nothing but the reset value before the first frame completes
    p_reset_zero_r7: assert property (@(posedge clk)
        !rst_n |=> (b1_out == 8'h00 && !len_err));
endmodule

// File: tb/frame_bip8_gen_test.sv
module frame_bip8_gen_test;
    localparam int FRAME = 648;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       err_inject = 1'b0;
    logic [7:0] b1_out;
    logic       len_err;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] macc = 8'h00;
    int         mcnt = 0;
    logic [7:0] exp_hold = 8'h00;
    logic       exp_len = 1'b0;

    always #5 clk = ~clk;

    frame_bip8_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .err_inject(err_inject),
        .b1_out(b1_out), .len_err(len_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int pat, input int i);
        case (pat)
            1: gen = 8'hFF;
            2: gen = (i == 5) ? 8'h80 : 8'h00;
            3: gen = 8'h01 << (i % 8);
            default: gen = 8'($urandom);
        endcase
    endfunction

    task automatic put(input logic [7:0] d, input logic s, input logic e, input logic inj);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = d;
        in_sof = s;
        in_eof = e;
        err_inject = e ? inj : 1'($urandom);
        if (s) begin
            macc = d;
            mcnt = 1;
        end else begin
            macc = macc ^ d;
            mcnt++;
        end
    endtask

    task automatic junk();
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 8'($urandom);
        in_sof = 1'($urandom);
        in_eof = 1'($urandom);
        err_inject = 1'($urandom);
    endtask

    task automatic frame(input int n, input logic inj, input logic gaps, input int pat, input string req);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 4 == 0)) junk();
            put(gen(pat, i), i == 0, i == n - 1, inj);
            if (i == n / 2) check({"R3 hold ", req}, b1_out, exp_hold);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_eof = 1'b0;
        err_inject = 1'b0;
        exp_hold = inj ? ~macc : macc;
        exp_len = (mcnt != FRAME);
        check({"R1 parity ", req}, b1_out, exp_hold);
        check({"R5 len_err ", req}, {7'b0, len_err}, {7'b0, exp_len});
    endtask

    task automatic partial(input int n);
        for (int i = 0; i < n; i++) put(8'($urandom), i == 0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R7 reset b1", b1_out, 8'h00);
        check("R7 reset len_err", {7'b0, len_err}, 8'h00);
        rst_n = 1'b1;
        repeat (3) junk();
        check("R7 idle b1", b1_out, 8'h00);
        check("R8 idle len_err", {7'b0, len_err}, 8'h00);
        frame(FRAME, 1'b0, 1'b0, 1, "R1 all ones");
        frame(FRAME, 1'b0, 1'b0, 2, "R1 single msb");
        frame(FRAME, 1'b0, 1'b0, 3, "R1 walking");
        frame(FRAME, 1'b0, 1'b1, 0, "R2 R8 gaps");
        frame(FRAME, 1'b1, 1'b0, 0, "R6 inject");
        frame(FRAME, 1'b0, 1'b1, 0, "R6 one frame only");
        frame(FRAME - 1, 1'b0, 1'b0, 0, "R5 short");
        frame(FRAME, 1'b0, 1'b0, 0, "R5 recovered");
        frame(FRAME + 1, 1'b1, 1'b1, 0, "R5 long inject");
        frame(10, 1'b0, 1'b0, 0, "R5 tiny");
        partial(100);
        frame(FRAME, 1'b0, 1'b1, 0, "R4 restart");
        partial(FRAME - 3);
        repeat (2) junk();
        frame(FRAME, 1'b0, 1'b0, 1, "R4 restart ones");
        for (int k = 0; k < 6; k++) frame(FRAME, 1'($urandom), 1'b1, 0, "R1 random");
        repeat (4) junk();
        check("R3 hold after idle", b1_out, exp_hold);
        check("R8 len_err after idle", {7'b0, len_err}, {7'b0, exp_len});
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule